// File: doc/BRIEF.md
# Two-Channel Cycle-Stealing DMA Controller

This block moves data between memory locations on a bus it shares with a processor. It has two independent channels. Each channel moves one byte or one 16-bit word per request. A request comes from a software write or from a rising edge on a peripheral interrupt line that the channel selects. The DMA side has the higher bus priority. It asks the arbiter for the bus and keeps it only for the two bus cycles of one transfer: one read from the source and one write to the destination. It then releases the bus, so the processor can use the cycles in between.

Each channel has these registers:

- a programmed source address and a programmed destination address;
- a reload value for the transfer counter;
- a working counter;
- one working (forward) pointer.

A control bit chooses which side the forward pointer follows: the source or the destination. That side steps by the transfer size after each transfer, and the other side stays at its programmed address. The programmed registers never change by themselves.

When the last transfer of a block completes, the channel does four things. It pulses its done output, reloads the counter, reloads the forward pointer from its base, and clears its enable bit unless repeat mode is set. A request that arrives while an earlier one is still pending is merged into it and not queued.

Top module: `dma2ch`

## Requirements
- R1: After reset every channel register reads zero, `bus_req_o` is low and `done_o` is zero.
- R2: A transfer reads the source and then writes the same data to the destination. Word mode (control bit 1 = 1) moves 16 bits with `bus_be_o`=11. Byte mode moves the byte selected by address bit 0 (lane 1 when it is 1, lane 0 when it is 0). The byte is written on the lane that the destination address bit 0 selects.
- R3: The forward pointer (register index 5) steps by 2 in word mode and by 1 in byte mode after each transfer. Control bit 3 = 0 makes it follow the source and bit 3 = 1 makes it follow the destination. The programmed source (index 0) and destination (index 1) registers keep their written values.
- R4: The counter (index 6) decrements once per transfer. A write to the reload register (index 2) loads both the reload value and the counter. When a transfer completes with the counter at 1, four things happen: `done_o` for that channel pulses for exactly one cycle, the counter reloads, the forward pointer returns to its base, and the enable bit (control bit 0) clears.
- R5: A software request is any write to index 4. A hardware request is a rising edge on `irq_i[sel]`, where sel is control bits 6:5, and it counts only when control bit 4 = 1. A level held high gives one request. Edges on lines that are not selected are ignored. No request is accepted while the enable bit is 0.
- R6: A request that arrives while the channel's request is still pending is merged, so two requests can yield a single transfer.
- R7: When both channels are pending in the same cycle, channel 0 is serviced first.
- R8: `bus_req_o` stays high with a stable address and direction until `bus_gnt_i` is seen. It drops in the cycle after the write of a transfer is granted.
- R9: The pending bit (index 7, bit 0) clears when its transfer starts and stays set while the channel waits for service.
- R10: With repeat mode set (control bit 2 = 1), the enable bit stays at 1 after the last transfer of a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address: bit 3 is the channel, bits 2:0 are the register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| irq_i | input | N_PERIPH | Peripheral interrupt request lines |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Bus grant; the current access completes on a clock edge where it is high |
| bus_addr_o | output | 20 | Bus address |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_be_o | output | 2 | Byte lane enables |
| bus_wdata_o | output | 16 | Write data |
| bus_rdata_i | input | 16 | Read data |
| done_o | output | 2 | One-cycle end-of-block pulse for each channel |

## Verification
The bench builds the block with its default parameters: two channels, 20-bit addresses, a 16-bit counter and four peripheral lines. Because there are four lines, a channel can select one line while a pulse arrives on another one. Block lengths stay between 1 and 5, so every random block runs through its terminal count, its reload and its enable clear many times. The grant is randomly stalled, which exercises request holding. Directed phases force the grant low to build up merged requests and a simultaneous request from both channels.

// File: rtl/dma2ch_pkg.sv
package dma2ch_pkg;
  typedef enum logic [1:0] {XF_IDLE, XF_RD, XF_WR} xf_state_e;

  localparam logic [2:0] IDX_SRC  = 3'd0;
  localparam logic [2:0] IDX_DST  = 3'd1;
  localparam logic [2:0] IDX_RLD  = 3'd2;
  localparam logic [2:0] IDX_CTL  = 3'd3;
  localparam logic [2:0] IDX_SWRQ = 3'd4;
  localparam logic [2:0] IDX_FWD  = 3'd5;
  localparam logic [2:0] IDX_CNT  = 3'd6;
  localparam logic [2:0] IDX_STAT = 3'd7;

  localparam int CTL_EN      = 0;
  localparam int CTL_WORD    = 1;
  localparam int CTL_RPT     = 2;
  localparam int CTL_FDST    = 3;
  localparam int CTL_TRIG_EN = 4;
  localparam int CTL_TSEL    = 5;
endpackage

// File: rtl/dma2ch_arb.sv
module dma2ch_arb #(
  parameter int NUM_CH = 2,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] req_i,
  output logic              valid_o,
  output logic [CH_W-1:0]   idx_o
);
  // lowest index wins
  always_comb begin
    idx_o   = '0;
    valid_o = |req_i;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = CH_W'(i);
    end
  end
endmodule

// File: rtl/dma2ch_chan.sv
module dma2ch_chan
  import dma2ch_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int CNT_W    = 16,
  parameter int N_PERIPH = 4,
  parameter int REG_W    = 32,
  localparam int SEL_W = (N_PERIPH > 1) ? $clog2(N_PERIPH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [2:0]        idx_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [N_PERIPH-1:0] irq_i,
  input  logic              start_i,
  input  logic              fin_i,
  output logic              pend_o,
  output logic              word_o,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic [REG_W-1:0]  rdata_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] src_q, dst_q, fwd_q, base, step;
  logic [CNT_W-1:0]  cnt_q, rld_q;
  logic              en_q, word_q, rpt_q, fdst_q, ten_q, pend_q, done_q;
  logic [SEL_W-1:0]  tsel_q;
  logic [N_PERIPH-1:0] irq_q;
  logic              trig, sw_req, last;

  assign base   = fdst_q ? dst_q : src_q;
  assign step   = word_q ? ADDR_W'(2) : ADDR_W'(1);
  assign last   = (cnt_q == CNT_W'(1));
  assign trig   = ten_q & irq_i[tsel_q] & ~irq_q[tsel_q];
  assign sw_req = wr_i && (idx_i == IDX_SWRQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      fwd_q  <= '0;
      cnt_q  <= '0;
      rld_q  <= '0;
      en_q   <= 1'b0;
      word_q <= 1'b0;
      rpt_q  <= 1'b0;
      fdst_q <= 1'b0;
      ten_q  <= 1'b0;
      tsel_q <= '0;
      pend_q <= 1'b0;
      irq_q  <= '0;
      done_q <= 1'b0;
    end else begin
      irq_q  <= irq_i;
      done_q <= 1'b0;
      if (start_i) pend_q <= 1'b0;
      // a new request outranks the clear: merged, not queued
      if ((sw_req || trig) && en_q) pend_q <= 1'b1;
      if (fin_i) begin
        if (last) begin
          cnt_q  <= rld_q;
          fwd_q  <= base;
          done_q <= 1'b1;
          en_q   <= rpt_q;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
          fwd_q <= fwd_q + step;
        end
      end
      if (wr_i) begin
        unique case (idx_i)
          IDX_SRC: begin
            src_q <= wdata_i[ADDR_W-1:0];
            if (!fdst_q) fwd_q <= wdata_i[ADDR_W-1:0];
          end
          IDX_DST: begin
            dst_q <= wdata_i[ADDR_W-1:0];
            if (fdst_q) fwd_q <= wdata_i[ADDR_W-1:0];
          end
          IDX_RLD: begin
            rld_q <= wdata_i[CNT_W-1:0];
            cnt_q <= wdata_i[CNT_W-1:0];
          end
          IDX_CTL: begin
            en_q   <= wdata_i[CTL_EN];
            word_q <= wdata_i[CTL_WORD];
            rpt_q  <= wdata_i[CTL_RPT];
            fdst_q <= wdata_i[CTL_FDST];
            ten_q  <= wdata_i[CTL_TRIG_EN];
            tsel_q <= wdata_i[CTL_TSEL +: SEL_W];
            fwd_q  <= wdata_i[CTL_FDST] ? dst_q : src_q;
            if (!wdata_i[CTL_EN]) pend_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign pend_o     = pend_q & en_q;
  assign word_o     = word_q;
  assign src_addr_o = fdst_q ? src_q : fwd_q;
  assign dst_addr_o = fdst_q ? fwd_q : dst_q;
  assign done_o     = done_q;

  always_comb begin
    rdata_o = '0;
    unique case (idx_i)
      IDX_SRC: rdata_o[ADDR_W-1:0] = src_q;
      IDX_DST: rdata_o[ADDR_W-1:0] = dst_q;
      IDX_RLD: rdata_o[CNT_W-1:0]  = rld_q;
      IDX_CTL: begin
        rdata_o[CTL_EN]           = en_q;
        rdata_o[CTL_WORD]         = word_q;
        rdata_o[CTL_RPT]          = rpt_q;
        rdata_o[CTL_FDST]         = fdst_q;
        rdata_o[CTL_TRIG_EN]      = ten_q;
        rdata_o[CTL_TSEL +: SEL_W] = tsel_q;
      end
      IDX_FWD:  rdata_o[ADDR_W-1:0] = fwd_q;
      IDX_CNT:  rdata_o[CNT_W-1:0]  = cnt_q;
      IDX_STAT: rdata_o[0]          = pend_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/dma2ch_xfer.sv
module dma2ch_xfer
  import dma2ch_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int NUM_CH = 2,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           sel_valid_i,
  input  logic [CH_W-1:0]                sel_idx_i,
  input  logic [NUM_CH-1:0][ADDR_W-1:0]  src_i,
  input  logic [NUM_CH-1:0][ADDR_W-1:0]  dst_i,
  input  logic [NUM_CH-1:0]              word_i,
  output logic [NUM_CH-1:0]              start_o,
  output logic [NUM_CH-1:0]              fin_o,
  output logic                           bus_req_o,
  input  logic                           bus_gnt_i,
  output logic [ADDR_W-1:0]              bus_addr_o,
  output logic                           bus_we_o,
  output logic [1:0]                     bus_be_o,
  output logic [15:0]                    bus_wdata_o,
  input  logic [15:0]                    bus_rdata_i
);
  localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);

  xf_state_e         state_q;
  logic [CH_W-1:0]   ch_q;
  logic [7:0]        lat_hi_q, lat_lo_q;
  logic [ADDR_W-1:0] rd_addr, wr_addr, cur_addr;
  logic              cur_word;

  assign rd_addr  = src_i[ch_q];
  assign wr_addr  = dst_i[ch_q];
  assign cur_word = word_i[ch_q];
  assign cur_addr = (state_q == XF_WR) ? wr_addr : rd_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= XF_IDLE;
      ch_q     <= '0;
      lat_hi_q <= '0;
      lat_lo_q <= '0;
    end else begin
      unique case (state_q)
        XF_IDLE: if (sel_valid_i) begin
          ch_q    <= sel_idx_i;
          state_q <= XF_RD;
        end
        XF_RD: if (bus_gnt_i) begin
          if (cur_word) begin
            lat_hi_q <= bus_rdata_i[15:8];
            lat_lo_q <= bus_rdata_i[7:0];
          end else begin
            lat_lo_q <= rd_addr[0] ? bus_rdata_i[15:8] : bus_rdata_i[7:0];
          end
          state_q <= XF_WR;
        end
        XF_WR: if (bus_gnt_i) state_q <= XF_IDLE;
        default: state_q <= XF_IDLE;
      endcase
    end
  end

  always_comb begin
    start_o     = '0;
    fin_o       = '0;
    bus_req_o   = 1'b0;
    bus_addr_o  = '0;
    bus_we_o    = 1'b0;
    bus_be_o    = 2'b00;
    bus_wdata_o = '0;
    if (state_q == XF_IDLE && sel_valid_i) start_o = ONE << sel_idx_i;
    if (state_q != XF_IDLE) begin
      bus_req_o  = 1'b1;
      bus_addr_o = cur_addr;
      bus_we_o   = (state_q == XF_WR);
      bus_be_o   = cur_word ? 2'b11 : (cur_addr[0] ? 2'b10 : 2'b01);
      if (state_q == XF_WR) begin
        bus_wdata_o = cur_word ? {lat_hi_q, lat_lo_q} : {lat_lo_q, lat_lo_q};
        if (bus_gnt_i) fin_o = ONE << ch_q;
      end
    end
  end
endmodule

// File: rtl/dma2ch.sv
module dma2ch
  import dma2ch_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int ADDR_W   = 20,
  parameter int CNT_W    = 16,
  parameter int N_PERIPH = 4,
  parameter int REG_W    = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)+2:0] reg_addr_i,
  input  logic [REG_W-1:0]      reg_wdata_i,
  output logic [REG_W-1:0]      reg_rdata_o,
  input  logic [N_PERIPH-1:0]   irq_i,
  output logic                  bus_req_o,
  input  logic                  bus_gnt_i,
  output logic [ADDR_W-1:0]     bus_addr_o,
  output logic                  bus_we_o,
  output logic [1:0]            bus_be_o,
  output logic [15:0]           bus_wdata_o,
  input  logic [15:0]           bus_rdata_i,
  output logic [NUM_CH-1:0]     done_o
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0][ADDR_W-1:0] src_a, dst_a;
  logic [NUM_CH-1:0][REG_W-1:0]  ch_rdata;
  logic [NUM_CH-1:0]             pend, word, start, fin;
  logic [CH_W-1:0]               sel_idx, reg_ch;
  logic                          sel_valid;

  assign reg_ch = reg_addr_i[3 +: CH_W];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma2ch_chan #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .N_PERIPH(N_PERIPH), .REG_W(REG_W)
    ) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (reg_we_i && (reg_ch == CH_W'(c))),
      .idx_i      (reg_addr_i[2:0]),
      .wdata_i    (reg_wdata_i),
      .irq_i      (irq_i),
      .start_i    (start[c]),
      .fin_i      (fin[c]),
      .pend_o     (pend[c]),
      .word_o     (word[c]),
      .src_addr_o (src_a[c]),
      .dst_addr_o (dst_a[c]),
      .rdata_o    (ch_rdata[c]),
      .done_o     (done_o[c])
    );
  end

  assign reg_rdata_o = ch_rdata[reg_ch];

  dma2ch_arb #(.NUM_CH(NUM_CH)) u_arb (
    .req_i   (pend),
    .valid_o (sel_valid),
    .idx_o   (sel_idx)
  );

  dma2ch_xfer #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_xfer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_valid_i (sel_valid),
    .sel_idx_i   (sel_idx),
    .src_i       (src_a),
    .dst_i       (dst_a),
    .word_i      (word),
    .start_o     (start),
    .fin_o       (fin),
    .bus_req_o   (bus_req_o),
    .bus_gnt_i   (bus_gnt_i),
    .bus_addr_o  (bus_addr_o),
    .bus_we_o    (bus_we_o),
    .bus_be_o    (bus_be_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_rdata_i (bus_rdata_i)
  );
endmodule

// File: rtl/dma2ch_chk.sv
module dma2ch_chk #(
  parameter int ADDR_W = 20,
  parameter int NUM_CH = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [1:0]        bus_be_o,
  input logic [NUM_CH-1:0] done_o
);
  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o));
  // R8
  req_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_gnt_i && bus_we_o |=> !bus_req_o);
  // R2
  rd_then_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_gnt_i && !bus_we_o |=> bus_req_o && bus_we_o);
  // R2
  lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> bus_be_o != 2'b00);
  // R4
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |done_o |-> $past(bus_req_o && bus_gnt_i && bus_we_o));
  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |done_o |=> !(|done_o));
  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o));
endmodule

bind dma2ch dma2ch_chk #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_req_o  (bus_req_o),
  .bus_gnt_i  (bus_gnt_i),
  .bus_we_o   (bus_we_o),
  .bus_addr_o (bus_addr_o),
  .bus_be_o   (bus_be_o),
  .done_o     (done_o)
);

// File: tb/dma2ch_tb.sv
module dma2ch_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [3:0]  irq = '0;
  logic        bus_req, bus_gnt = 1'b0, bus_we;
  logic [19:0] bus_addr;
  logic [1:0]  bus_be, done;
  logic [15:0] bus_wdata, bus_rdata;

  logic [7:0]  mem [0:8191];
  logic [7:0]  em  [0:8191];
  int          gnt_mode = 2;
  int          n_chk = 0, n_fail = 0;

  logic [19:0] m_src [2], m_dst [2], m_fwd [2];
  logic [15:0] m_cnt [2], m_rld [2];
  bit          m_word [2], m_fdst [2], m_rpt [2], m_en [2];
  int          exp_done [2], obs_done [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma2ch u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_i(irq),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_addr_o(bus_addr),
    .bus_we_o(bus_we), .bus_be_o(bus_be), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(bus_rdata), .done_o(done)
  );

  assign bus_rdata = {mem[{bus_addr[12:1], 1'b1}], mem[{bus_addr[12:1], 1'b0}]};

  always @(posedge clk) begin
    if (bus_req && bus_gnt && bus_we) begin
      if (bus_be[0]) mem[{bus_addr[12:1], 1'b0}] <= bus_wdata[7:0];
      if (bus_be[1]) mem[{bus_addr[12:1], 1'b1}] <= bus_wdata[15:8];
    end
    if (rst_n && done[0]) obs_done[0] <= obs_done[0] + 1;
    if (rst_n && done[1]) obs_done[1] <= obs_done[1] + 1;
  end

  always @(negedge clk)
    bus_gnt <= (gnt_mode == 2) ? 1'b1 : (gnt_mode == 1) ? (($urandom % 4) != 0) : 1'b0;

  function automatic logic [31:0] mk_ctl(bit en, bit word, bit rpt, bit fdst, bit ten, int tsel);
    logic [31:0] v = '0;
    v[0] = en; v[1] = word; v[2] = rpt; v[3] = fdst; v[4] = ten; v[6:5] = 2'(tsel);
    return v;
  endfunction

  function automatic logic [19:0] m_base(int ch);
    return m_fdst[ch] ? m_dst[ch] : m_src[ch];
  endfunction

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int ch, int idx, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {1'(ch), 3'(idx)}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int ch, int idx, output logic [31:0] d);
    @(negedge clk);
    reg_addr = {1'(ch), 3'(idx)};
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (bus_req) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic prog(int ch, logic [19:0] s, logic [19:0] d, logic [15:0] n, logic [31:0] ctl);
    wr(ch, 0, {12'h0, s});
    wr(ch, 1, {12'h0, d});
    wr(ch, 2, {16'h0, n});
    wr(ch, 3, ctl);
    m_src[ch] = s; m_dst[ch] = d; m_rld[ch] = n; m_cnt[ch] = n;
    m_en[ch] = ctl[0]; m_word[ch] = ctl[1]; m_rpt[ch] = ctl[2]; m_fdst[ch] = ctl[3];
    m_fwd[ch] = m_base(ch);
  endtask

  task automatic model_xfer(int ch);
    logic [19:0] s, d;
    s = m_fdst[ch] ? m_src[ch] : m_fwd[ch];
    d = m_fdst[ch] ? m_fwd[ch] : m_dst[ch];
    if (m_word[ch]) begin
      em[{d[12:1], 1'b0}] = em[{s[12:1], 1'b0}];
      em[{d[12:1], 1'b1}] = em[{s[12:1], 1'b1}];
    end else begin
      em[d[12:0]] = em[s[12:0]];
    end
    if (m_cnt[ch] == 16'd1) begin
      m_cnt[ch] = m_rld[ch]; m_fwd[ch] = m_base(ch); m_en[ch] = m_rpt[ch]; exp_done[ch]++;
    end else begin
      m_cnt[ch] = m_cnt[ch] - 16'd1;
      m_fwd[ch] = m_fwd[ch] + (m_word[ch] ? 20'd2 : 20'd1);
    end
  endtask

  task automatic mem_chk(string tag);
    int bad = -1;
    for (int i = 0; i < 8192; i++) if (bad < 0 && mem[i] !== em[i]) bad = i;
    if (bad < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, tag, {bad[15:0], 8'h0, mem[bad]}, {bad[15:0], 8'h0, em[bad]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
    report();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20251));
    for (int i = 0; i < 8192; i++) begin mem[i] = 8'($urandom); em[i] = mem[i]; end
    for (int c = 0; c < 2; c++) begin exp_done[c] = 0; obs_done[c] = 0; end
    repeat (4) @(negedge clk);
    #1 chk(!bus_req && done == 2'b00, "R1 bus idle", {bus_req, done}, 0);
    rst_n = 1'b1;
    rd(0, 3, v); chk(v == 0, "R1 ctrl0", v, 0);
    rd(1, 6, v); chk(v == 0, "R1 cnt1", v, 0);
    rd(1, 5, v); chk(v == 0, "R1 fwd1", v, 0);

    // random blocks with stalled grants
    gnt_mode = 1;
    for (int it = 0; it < 24; it++) begin
      int ch = $urandom % 2;
      bit wd = 1'($urandom), fd = 1'($urandom);
      int n = 1 + $urandom % 5;
      logic [19:0] s = 20'($urandom % 20'h800), d = 20'h1000 + 20'($urandom % 20'h800);
      if (wd) begin s[0] = 1'b0; d[0] = 1'b0; end
      prog(ch, s, d, 16'(n), mk_ctl(1, wd, 0, fd, 0, 0));
      for (int k = 0; k < n; k++) begin
        wr(ch, 4, 0);
        model_xfer(ch);
        wait_idle();
        if (k == 0 && n > 1) begin
          rd(ch, 5, v);
          chk(v == {12'h0, m_fwd[ch]}, "R3 fwd step", v, {12'h0, m_fwd[ch]});
        end
      end
      rd(ch, 6, v); chk(v == {16'h0, m_cnt[ch]}, "R4 cnt reload", v, {16'h0, m_cnt[ch]});
      rd(ch, 3, v); chk(v[0] == 1'b0, "R4 enable clear", v, 0);
      rd(ch, 5, v); chk(v == {12'h0, m_base(ch)}, "R4 fwd reload", v, {12'h0, m_base(ch)});
      rd(ch, 0, v); chk(v == {12'h0, s}, "R3 src kept", v, {12'h0, s});
      rd(ch, 1, v); chk(v == {12'h0, d}, "R3 dst kept", v, {12'h0, d});
      chk(obs_done[ch] == exp_done[ch], "R4 done count", obs_done[ch], exp_done[ch]);
      mem_chk("R2 data moved");
    end

    // R5 disabled channel ignores request
    gnt_mode = 2;
    prog(0, 20'h0100, 20'h1100, 16'd4, mk_ctl(0, 0, 0, 0, 0, 0));
    wr(0, 4, 0);
    repeat (8) @(negedge clk);
    rd(0, 6, v); chk(v == 4, "R5 disabled no count", v, 4);
    rd(0, 7, v); chk(v[0] == 1'b0, "R5 disabled no pend", v, 0);
    mem_chk("R5 disabled no data");

    // R6 R9 merge while stalled
    gnt_mode = 0;
    prog(0, 20'h0200, 20'h1200, 16'd5, mk_ctl(1, 1, 0, 0, 0, 0));
    wr(0, 4, 0); wr(0, 4, 0); wr(0, 4, 0);
    repeat (2) @(negedge clk);
    chk(bus_req && !bus_we && bus_addr == 20'h0200, "R8 held read", {bus_req, bus_we, bus_addr}, {2'b10, 20'h0200});
    rd(0, 7, v); chk(v[0] == 1'b1, "R9 pend held", v, 1);
    model_xfer(0); model_xfer(0);
    gnt_mode = 2;
    wait_idle(); wait_idle();
    rd(0, 6, v); chk(v == 3, "R6 merged count", v, 3);
    rd(0, 7, v); chk(v[0] == 1'b0, "R9 pend cleared", v, 0);
    mem_chk("R6 merged data");

    // R7 priority, R5 irq edge and select
    gnt_mode = 0;
    prog(0, 20'h0300, 20'h1300, 16'd3, mk_ctl(1, 0, 0, 0, 1, 1));
    prog(1, 20'h0401, 20'h1402, 16'd3, mk_ctl(1, 0, 0, 1, 1, 1));
    @(negedge clk); irq[1] = 1'b1;
    repeat (2) @(negedge clk);
    #1 chk(bus_req && bus_addr == 20'h0300, "R7 ch0 first", bus_addr, 20'h0300);
    rd(1, 7, v); chk(v[0] == 1'b1, "R7 ch1 waits", v, 1);
    model_xfer(0); model_xfer(1);
    gnt_mode = 2;
    repeat (14) @(negedge clk);
    rd(0, 6, v); chk(v == 2, "R5 edge ch0", v, 2);
    rd(1, 6, v); chk(v == 2, "R5 edge ch1", v, 2);
    irq[1] = 1'b0; @(negedge clk); irq[2] = 1'b1;
    repeat (10) @(negedge clk);
    irq[2] = 1'b0;
    rd(1, 6, v); chk(v == 2, "R5 unselected line", v, 2);
    mem_chk("R7 data");

    // R10 repeat mode
    prog(1, 20'h0500, 20'h1500, 16'd2, mk_ctl(1, 0, 1, 0, 0, 0));
    for (int k = 0; k < 3; k++) begin wr(1, 4, 0); model_xfer(1); wait_idle(); end
    rd(1, 3, v); chk(v[0] == 1'b1, "R10 enable kept", v, 1);
    rd(1, 6, v); chk(v == 1, "R10 cnt", v, 1);
    chk(obs_done[1] == exp_done[1], "R10 done", obs_done[1], exp_done[1]);
    mem_chk("R10 data");
    report();
  end
endmodule